// File: doc/BRIEF.md
# Cascaded Wide Binary Counter and Programmable Divider

This block builds one wide synchronous up-counter from several identical narrow presettable stages that share a clock. Each stage reports an active-low terminal-count flag that is low whenever all of its bits are ones. No stage sees a binary carry. A stage may advance only when the terminal-count flag of every stage below it is low. The lowest stage advances on every enabled clock. When a stage advances, every stage below it wraps to zero on the same edge, and that wrap returns the higher stage to hold.

There are two modes. In free-count mode the chain counts up and wraps from all ones to zero. In divide mode, every stage loads its slice of the preset word only when the whole chain reads all ones. The OR of all stage flags drives every stage's load input, and the per-stage self-reload stays unused. The chain-wide terminal-count output is low for exactly one clock per period. That period is 2^W minus the preset, so a small ratio is set by writing a preset close to all ones.

A synchronous reset loads the preset, so the first divide period after reset is full length. A global enable freezes both counting and reloading. When the chain has a single stage, the stage's own terminal-count reload is used instead of the external gating.

Top module: `cnt_chain`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` takes the value of `preset` on that edge, in either mode.
- R2: With `cnt_en` high and `count` not all ones, each rising edge sets `count` to its previous value plus one.
- R3: A stage above the lowest one advances only on an edge where every lower 8-bit stage holds all ones. On that edge the lower stages become zero, so a carry crosses bit boundaries 8, 16 and 24 in a single clock.
- R4: In free-count mode (`mode_div` = 0), an enabled edge with `count` all ones sets `count` to zero.
- R5: `tc_n` is low in exactly those cycles in which `count` is all ones, with no added clock delay.
- R6: In divide mode (`mode_div` = 1), an enabled edge with `count` all ones loads `preset`, so `tc_n` falls once every 2^32 − `preset` enabled clocks.
- R7: In divide mode, no reload happens when only some stages are all ones. For example, `count` = 0xFFFFFEFF is followed by 0xFFFFFF00.
- R8: With `cnt_en` low, `count` keeps its value and no reload occurs, even at all ones in divide mode.
- R9: A change of `preset` while running has no effect on `count` until the next reload or reset.
- R10: With `preset` = 0xFFFFFFFF in divide mode (a ratio of one), `count` stays all ones and `tc_n` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common rising-edge clock for all stages |
| rst | input | 1 | Synchronous reset, active high; loads the preset |
| mode_div | input | 1 | 0 = free count with wrap, 1 = divide with reload at all ones |
| cnt_en | input | 1 | Global enable, active high; low freezes count and reload |
| preset | input | 32 | Reload value; stage k takes bits [8k+7:8k] |
| count | output | 32 | Chain count value |
| tc_n | output | 1 | Chain terminal count / divide output, active low |

## Verification
A broken carry gate shows at the ports within one clock. The count skips or repeats a value at a byte boundary, so the next sample no longer equals the previous value plus one. A reload condition that is wrong in divide mode appears at the first state where a single stage reads all ones: the count jumps to the preset instead of carrying, and `tc_n` pulses early, which shortens the measured period. A stage whose hold logic is wrong under a low enable moves its byte on the next edge. The count is compared with a plain 32-bit reference on every clock, so each of these faults is reported in the cycle it first appears.

// File: rtl/cnt_chain_pkg.sv
package cnt_chain_pkg;

    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_DIV  = 1'b1
    } chain_mode_e;

    // A stage is at terminal count when every bit is one.
    function automatic logic all_ones8(input logic [7:0] v);
        return &v;
    endfunction

endpackage

// File: rtl/cnt_stage.sv
module cnt_stage #(
    parameter int STAGE_W = 8
) (
    input  logic               clk,
    input  logic               mr,
    input  logic               ce_n,
    input  logic               pe_n,
    input  logic               tcld,
    input  logic [STAGE_W-1:0] p,
    output logic [STAGE_W-1:0] q,
    output logic               tc_n
);

    typedef struct packed {
        logic [STAGE_W-1:0] q;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic      at_top;

    assign at_top = &st_q.q;

    always_comb begin
        st_d = st_q;
        if (mr) begin
            st_d.q = p;
        end else if (!pe_n) begin
            st_d.q = p;
        end else if (!ce_n) begin
            if (tcld && at_top) begin
                st_d.q = p;
            end else begin
                st_d.q = st_q.q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q    = st_q.q;
    assign tc_n = ~at_top;

endmodule

// File: rtl/cnt_carry_gate.sv
module cnt_carry_gate #(
    parameter int NUM_STAGES = 4
) (
    input  logic                  en,
    input  logic                  div,
    input  logic [NUM_STAGES-1:0] tc_n,
    output logic [NUM_STAGES-1:0] ce_n,
    output logic [NUM_STAGES-1:0] pe_n,
    output logic [NUM_STAGES-1:0] tcld,
    output logic                  chain_tc_n
);

    // pre_n[k] is the OR of the flags of stages 0..k-1
    logic [NUM_STAGES:0] pre_n;

    assign pre_n[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < NUM_STAGES; k++) begin : g_gate
            assign pre_n[k+1] = pre_n[k] | tc_n[k];
            if (k == 0) begin : g_low
                assign ce_n[k] = ~en;
            end else if (k == 1) begin : g_direct
                assign ce_n[k] = tc_n[0] | ~en;
            end else begin : g_or
                assign ce_n[k] = pre_n[k] | ~en;
            end
        end

        if (NUM_STAGES == 1) begin : g_single
            assign pe_n = 1'b1;
            assign tcld = div;
        end else begin : g_multi
            for (k = 0; k < NUM_STAGES; k++) begin : g_pe
                assign pe_n[k] = ~(div & en & ~pre_n[NUM_STAGES]);
                assign tcld[k] = 1'b0;
            end
        end
    endgenerate

    assign chain_tc_n = pre_n[NUM_STAGES];

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
    parameter int STAGE_W    = 8,
    parameter int NUM_STAGES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mode_div,
    input  logic                          cnt_en,
    input  logic [STAGE_W*NUM_STAGES-1:0] preset,
    output logic [STAGE_W*NUM_STAGES-1:0] count,
    output logic                          tc_n
);
    import cnt_chain_pkg::*;

    localparam int W = STAGE_W * NUM_STAGES;

    chain_mode_e           mode;
    logic [NUM_STAGES-1:0] st_tc_n;
    logic [NUM_STAGES-1:0] st_ce_n;
    logic [NUM_STAGES-1:0] st_pe_n;
    logic [NUM_STAGES-1:0] st_tcld;
    logic                  chain_tc_n;

    assign mode = chain_mode_e'(mode_div);

    cnt_carry_gate #(
        .NUM_STAGES(NUM_STAGES)
    ) u_gate (
        .en        (cnt_en),
        .div       (mode == MODE_DIV),
        .tc_n      (st_tc_n),
        .ce_n      (st_ce_n),
        .pe_n      (st_pe_n),
        .tcld      (st_tcld),
        .chain_tc_n(chain_tc_n)
    );

    genvar s;
    generate
        for (s = 0; s < NUM_STAGES; s++) begin : g_stage
            cnt_stage #(
                .STAGE_W(STAGE_W)
            ) u_stage (
                .clk (clk),
                .mr  (rst),
                .ce_n(st_ce_n[s]),
                .pe_n(st_pe_n[s]),
                .tcld(st_tcld[s]),
                .p   (preset[s*STAGE_W +: STAGE_W]),
                .q   (count[s*STAGE_W +: STAGE_W]),
                .tc_n(st_tc_n[s])
            );
        end
    endgenerate

    assign tc_n = chain_tc_n;

endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         mode_div,
    input logic         cnt_en,
    input logic [W-1:0] preset,
    input logic [W-1:0] count,
    input logic         tc_n
);

    // R1: reset loads the preset
    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> count == $past(preset));

    // R2: plain increment below all ones
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count != '1) |=> count == $past(count) + 1'b1);

    // R4: free mode wraps to zero
    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !mode_div && count == '1) |=> count == '0);

    // R5: flag tracks all ones with no delay
    assert_tc_R5: assert property (@(posedge clk) disable iff (rst)
        tc_n == (count != '1));

    // R6: divide mode reload at all ones
    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && mode_div && count == '1) |=> count == $past(preset));

    // R8: disabled chain holds
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count));

endmodule

bind cnt_chain cnt_chain_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_div(mode_div),
    .cnt_en  (cnt_en),
    .preset  (preset),
    .count   (count),
    .tc_n    (tc_n)
);

// File: tb/cnt_chain_test.sv
`timescale 1ns/1ps
module cnt_chain_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_div = 1'b0;
    logic        cnt_en = 1'b0;
    logic [31:0] preset = 32'h0;
    logic [31:0] count;
    logic        tc_n;

    logic [31:0] ref_q = 32'h0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cnt_chain uut (
        .clk     (clk),
        .rst     (rst),
        .mode_div(mode_div),
        .cnt_en  (cnt_en),
        .preset  (preset),
        .count   (count),
        .tc_n    (tc_n)
    );

    // {mode, preset, cycles}
    localparam int NV = 9;
    localparam logic [48:0] VEC [NV] = '{
        {1'b0, 32'hFFFF_FFF0, 16'd40},   // R4 wrap
        {1'b0, 32'h0000_00F8, 16'd20},   // R3 carry into byte 1
        {1'b0, 32'h0000_FFFA, 16'd12},   // R3 carry into byte 2
        {1'b0, 32'h00FF_FFFC, 16'd10},   // R3 carry into byte 3
        {1'b1, 32'hFFFF_FFF6, 16'd45},   // R6 ratio 10
        {1'b1, 32'hFFFF_FF00, 16'd600},  // R6 ratio 256
        {1'b1, 32'hFFFF_FEFD, 16'd600},  // R7 ratio 259
        {1'b1, 32'hFFFF_FFFE, 16'd10},   // R6 ratio 2
        {1'b1, 32'hFFFF_FFFF, 16'd6}     // R10 ratio 1
    };
    localparam string VTAG [NV] = '{"R4", "R3", "R3", "R3", "R6", "R6", "R7", "R6", "R10"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        if (rst) ref_q = preset;
        else if (cnt_en) begin
            if (mode_div && ref_q == 32'hFFFF_FFFF) ref_q = preset;
            else ref_q = ref_q + 1;
        end
        #1;
        check(tag, count, ref_q);
        check("R5", {31'b0, tc_n}, {31'b0, ref_q != 32'hFFFF_FFFF});
    endtask

    task automatic do_reset(input logic md, input logic [31:0] pv);
        rst = 1'b1; cnt_en = 1'b0; mode_div = md; preset = pv;
        tick("R1");
        tick("R1");
        rst = 1'b0; cnt_en = 1'b1;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int pulses;
        int last_t;
        int gap;
        // reset state, R1
        do_reset(1'b0, 32'h1234_5678);
        check("R1", count, 32'h1234_5678);

        for (int v = 0; v < NV; v++) begin
            do_reset(VEC[v][48], VEC[v][47:16]);
            for (int c = 0; c < int'(VEC[v][15:0]); c++) tick(VTAG[v]);
        end

        // R2 plain increments from zero
        do_reset(1'b0, 32'h0);
        for (int c = 0; c < 5; c++) tick("R2");
        check("R2", count, 32'd5);

        // R7 explicit: partial all ones does not reload
        do_reset(1'b1, 32'hFFFF_FEFE);
        tick("R7");
        check("R7", count, 32'hFFFF_FEFF);
        tick("R7");
        check("R7", count, 32'hFFFF_FF00);

        // R8 hold at all ones in divide mode
        do_reset(1'b1, 32'hFFFF_FFFD);
        tick("R8"); tick("R8");
        check("R8", count, 32'hFFFF_FFFF);
        cnt_en = 1'b0;
        for (int c = 0; c < 5; c++) tick("R8");
        check("R8", count, 32'hFFFF_FFFF);
        check("R8", {31'b0, tc_n}, 32'd0);
        cnt_en = 1'b1;
        tick("R8");
        check("R8", count, 32'hFFFF_FFFD);

        // R8 hold mid-count across byte boundary
        do_reset(1'b0, 32'h0000_00FE);
        tick("R8");
        cnt_en = 1'b0;
        tick("R8"); tick("R8");
        check("R8", count, 32'h0000_00FF);

        // R9 preset change mid-period
        do_reset(1'b1, 32'hFFFF_FFF6);
        tick("R9"); tick("R9");
        preset = 32'hFFFF_FFF0;
        tick("R9");
        check("R9", count, 32'hFFFF_FFF9);
        for (int c = 0; c < 7; c++) tick("R9");
        check("R9", count, 32'hFFFF_FFF0);

        // R6 period measured on tc_n, ratio 10
        do_reset(1'b1, 32'hFFFF_FFF6);
        pulses = 0; last_t = -1; gap = 0;
        for (int c = 0; c < 40; c++) begin
            tick("R6");
            if (!tc_n) begin
                if (last_t >= 0) begin
                    gap = c - last_t;
                    check("R6", gap, 32'd10);
                end
                last_t = c;
                pulses++;
            end
        end
        check("R6", pulses, 32'd4);

        // R10 ratio one holds all ones
        do_reset(1'b1, 32'hFFFF_FFFF);
        for (int c = 0; c < 4; c++) tick("R10");
        check("R10", count, 32'hFFFF_FFFF);
        check("R10", {31'b0, tc_n}, 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule